// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block gathers up to sixteen peripheral request lines and turns them into one prioritized interrupt request with a 3-bit level. Each source owns a byte-wide control register. That register selects the source's level, enable, trigger mode (level or edge) and input polarity. Software reads the same register to see whether the source is pending.

A general control register holds the master enable. A vector base register sets the upper part of the returned vector, and a mask register can block any of the seven levels. The output level is always the highest level among the sources that are currently allowed to interrupt.

When the processor acknowledges a level, the block picks the highest-numbered pending source at that level. One cycle later it returns the vector base plus that source's 4-bit code. Source code 11 is a permanent hole: it has no register, it never becomes pending, and its vector is never produced. All registers sit on a simple single-cycle byte bus: a write strobe with combinational read data.

Top module: `vec_intc`

## Requirements
- R1: After reset, every source control register reads 0x00, the general control register (address 0x10) reads 0x00, the vector base (address 0x11) reads 0x00, the level mask (address 0x12) reads 0xFE, and `irq_lvl` is 0.
- R2: The control register of source i sits at address i (0x00 to 0x0F) and reads as follows: bits [2:0] are the level, bit 3 reads 0, bit 4 is the enable, bit 5 is the read-only pending flag, bit 6 is the trigger mode (0 = level, 1 = edge) and bit 7 is the polarity (0 = high/rising, 1 = low/falling).
- R3: In edge mode, an active edge of the polarity-corrected input latches the source as pending. The latch holds until a write to the source's control register with bits 6 and 3 both set. If an edge arrives in the same cycle as that clearing write, the edge wins and the source stays pending.
- R4: In level mode, the pending flag equals the polarity-corrected input. Writing bit 3 has no effect on it.
- R5: While bit 1 of the general control register is 0, `irq_lvl` is 0.
- R6: A source whose enable bit is 0, or whose level field is 0, never contributes to `irq_lvl`.
- R7: `irq_lvl` equals the highest level among sources that are pending, enabled, have a nonzero level, and are not masked.
- R8: A one-cycle `iack` pulse with `iack_lvl` = L makes `vec_vld` go high in the next cycle, with `vec_o` = base + the code of the highest-code active source at level L (8-bit wraparound). If no active source is at level L, `vec_vld` stays 0.
- R9: Mask register bit n (n = 1 to 7) set to 0 blocks every source of level n from `irq_lvl` and from acknowledge.
- R10: Source code 11 has no storage: its register reads 0x00 whatever is written, it never raises a request, and no vector with code 11 is ever returned.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | NSRC | Peripheral request lines, one per source code |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | AW | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| irq_lvl | output | 3 | Current requested level, 0 = none |
| iack | input | 1 | Acknowledge strobe |
| iack_lvl | input | 3 | Level being acknowledged |
| vec_o | output | 8 | Returned vector |
| vec_vld | output | 1 | vec_o is valid this cycle |

## Verification
The two functions that can meet in one clock are the arrival of an edge on an edge-mode source and the software write that clears that source's latch. The bench first clears a latched edge on its own to show that the clear works. It then drives a new rising edge and the clearing write so that both land on the same rising clock edge. Reading the control register afterwards must still show the pending flag and the nonzero request level, because the edge takes precedence.

// File: rtl/vec_intc.sv
module vec_intc #(
  parameter int NSRC = 16,
  parameter int AW   = 5,
  parameter int HOLE = 11
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] req_i,
  input  logic            bus_wr,
  input  logic [AW-1:0]   bus_addr,
  input  logic [7:0]      bus_wdata,
  output logic [7:0]      bus_rdata,
  output logic [2:0]      irq_lvl,
  input  logic            iack,
  input  logic [2:0]      iack_lvl,
  output logic [7:0]      vec_o,
  output logic            vec_vld
);
  localparam int CW = $clog2(NSRC);
  localparam logic [AW-1:0] A_GEN  = AW'(NSRC);
  localparam logic [AW-1:0] A_BASE = AW'(NSRC + 1);
  localparam logic [AW-1:0] A_MASK = AW'(NSRC + 2);

  logic [7:0] gen_q, base_q, mask_q;
  logic [NSRC-1:0] act;
  logic [7:0] rd_a [NSRC];
  logic [2:0] lvl_a [NSRC];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      gen_q <= 8'h00; base_q <= 8'h00; mask_q <= 8'hFE;
    end else if (bus_wr) begin
      if (bus_addr == A_GEN)  gen_q  <= bus_wdata;
      if (bus_addr == A_BASE) base_q <= bus_wdata;
      if (bus_addr == A_MASK) mask_q <= bus_wdata & 8'hFE;
    end

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    if (i == HOLE) begin : g_hole
      assign rd_a[i]  = 8'h00;
      assign lvl_a[i] = 3'd0;
      assign act[i]   = 1'b0;
    end else begin : g_live
      logic [7:0] ctrl;
      logic prev, latch, cur, pend, hit, clr;
      assign hit = bus_wr && (bus_addr == AW'(i));
      assign clr = hit && bus_wdata[3] && bus_wdata[6];
      assign cur = req_i[i] ^ ctrl[7];

      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) begin
          ctrl <= 8'h00; prev <= 1'b0; latch <= 1'b0;
        end else begin
          if (hit) ctrl <= bus_wdata & 8'hD7;
          prev <= cur;
          if (!ctrl[6])          latch <= 1'b0;
          else if (cur && !prev) latch <= 1'b1;
          else if (clr)          latch <= 1'b0;
        end

      assign pend     = ctrl[6] ? latch : cur;
      assign lvl_a[i] = ctrl[2:0];
      assign act[i]   = pend && ctrl[4] && (ctrl[2:0] != 3'd0) &&
                        mask_q[ctrl[2:0]] && gen_q[1];
      assign rd_a[i]  = {ctrl[7:6], pend, ctrl[4], 1'b0, ctrl[2:0]};

      // R3
      latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl[6] && latch && !clr) |=> latch);
    end
  end

  always_comb begin
    irq_lvl = 3'd0;
    for (int i = 0; i < NSRC; i++)
      if (act[i] && lvl_a[i] > irq_lvl) irq_lvl = lvl_a[i];
  end

  logic          win;
  logic [CW-1:0] win_code;
  always_comb begin
    win = 1'b0;
    win_code = '0;
    for (int i = 0; i < NSRC; i++)
      if (act[i] && lvl_a[i] == iack_lvl) begin
        win = 1'b1;
        win_code = CW'(i);
      end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      vec_o <= 8'h00; vec_vld <= 1'b0;
    end else begin
      vec_vld <= iack && win;
      if (iack && win) vec_o <= base_q + 8'(win_code);
    end

  always_comb begin
    bus_rdata = 8'h00;
    if (bus_addr < AW'(NSRC)) bus_rdata = rd_a[bus_addr[CW-1:0]];
    else if (bus_addr == A_GEN)  bus_rdata = gen_q;
    else if (bus_addr == A_BASE) bus_rdata = base_q;
    else if (bus_addr == A_MASK) bus_rdata = mask_q;
  end

  // R5
  mien_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_lvl != 3'd0) |-> gen_q[1]);
  // R9
  level_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_lvl != 3'd0) |-> mask_q[irq_lvl]);
  // R8
  vec_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vec_vld |-> $past(iack));
  // R10
  no_hole_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vec_vld |-> ((vec_o - $past(base_q)) != 8'(HOLE)));
endmodule

// File: tb/vec_intc_tb.sv
module vec_intc_tb;
  logic clk = 0, rst_n = 0;
  logic [15:0] req_i = '0;
  logic bus_wr = 0, iack = 0;
  logic [4:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [2:0] iack_lvl = '0;
  logic [7:0] bus_rdata, vec_o;
  logic [2:0] irq_lvl;
  logic vec_vld;
  int errors = 0, checks = 0;
  bit done = 0;

  always #5 clk = ~clk;

  vec_intc u_dut (.clk, .rst_n, .req_i, .bus_wr, .bus_addr, .bus_wdata,
    .bus_rdata, .irq_lvl, .iack, .iack_lvl, .vec_o, .vec_vld);

  task automatic chk(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(input logic [4:0] a, input logic [7:0] exp, input string tag);
    bus_addr = a; #1;
    chk(bus_rdata, exp, tag);
  endtask

  task automatic ack(input logic [2:0] l, input bit exp_v, input logic [7:0] exp_vec, input string tag);
    iack = 1; iack_lvl = l;
    @(negedge clk);
    iack = 0;
    chk(vec_vld, exp_v, tag);
    if (exp_v) chk(vec_o, exp_vec, tag);
  endtask

  task automatic t_reset;
    rd(5'h00, 8'h00, "R1 ctrl0");
    rd(5'h10, 8'h00, "R1 gen");
    rd(5'h11, 8'h00, "R1 base");
    rd(5'h12, 8'hFE, "R1 mask");
    chk(irq_lvl, 0, "R1 irq_lvl");
  endtask

  task automatic t_fields;
    wr(5'h03, 8'h5D);
    rd(5'h03, 8'h55, "R2 readback drops bit3");
    wr(5'h03, 8'h00);
  endtask

  task automatic t_edge;
    wr(5'h10, 8'h02);
    wr(5'h03, 8'h55);
    chk(irq_lvl, 0, "R3 no edge yet");
    req_i[3] = 1; @(negedge clk); req_i[3] = 0; @(negedge clk);
    rd(5'h03, 8'h75, "R3 edge latched");
    chk(irq_lvl, 5, "R3 edge irq");
    wr(5'h03, 8'h5D);
    rd(5'h03, 8'h55, "R3 cleared");
    chk(irq_lvl, 0, "R3 irq after clear");
    req_i[3] = 1; bus_wr = 1; bus_addr = 5'h03; bus_wdata = 8'h5D;
    @(negedge clk);
    bus_wr = 0; req_i[3] = 0;
    rd(5'h03, 8'h75, "R3 edge wins over clear");
    chk(irq_lvl, 5, "R3 irq edge wins");
    wr(5'h03, 8'h5D); wr(5'h03, 8'h00);
  endtask

  task automatic t_level;
    wr(5'h07, 8'h93);
    rd(5'h07, 8'hB3, "R4 low-active pending");
    chk(irq_lvl, 3, "R4 irq");
    wr(5'h07, 8'h9B);
    rd(5'h07, 8'hB3, "R4 clear ignored");
    req_i[7] = 1; #1;
    rd(5'h07, 8'h93, "R4 follows input");
    chk(irq_lvl, 0, "R4 irq drop");
    wr(5'h07, 8'h00); req_i[7] = 0;
  endtask

  task automatic t_master;
    req_i[2] = 1;
    wr(5'h02, 8'h14);
    chk(irq_lvl, 4, "R7 single source");
    wr(5'h10, 8'h00);
    chk(irq_lvl, 0, "R5 master off");
    wr(5'h10, 8'h02);
    chk(irq_lvl, 4, "R5 master on");
  endtask

  task automatic t_disable;
    wr(5'h02, 8'h10);
    chk(irq_lvl, 0, "R6 level zero");
    wr(5'h02, 8'h04);
    chk(irq_lvl, 0, "R6 enable off");
    wr(5'h02, 8'h00); req_i[2] = 0;
  endtask

  task automatic t_prio;
    wr(5'h11, 8'h40);
    req_i[1] = 1; req_i[9] = 1; req_i[12] = 1;
    wr(5'h01, 8'h12); wr(5'h09, 8'h16); wr(5'h0C, 8'h16);
    chk(irq_lvl, 6, "R7 highest level");
    ack(3'd6, 1, 8'h4C, "R8 highest code at level");
    ack(3'd2, 1, 8'h41, "R8 lower level");
    ack(3'd1, 0, 8'h00, "R8 empty level");
    req_i[12] = 0; #1;
    ack(3'd6, 1, 8'h49, "R8 next code");
    req_i[12] = 1;
    wr(5'h11, 8'hF8);
    ack(3'd6, 1, 8'h04, "R8 wraparound");
  endtask

  task automatic t_mask;
    wr(5'h12, 8'hBE);
    chk(irq_lvl, 2, "R9 level 6 masked");
    ack(3'd6, 0, 8'h00, "R9 masked ack");
    wr(5'h12, 8'hFF);
    rd(5'h12, 8'hFE, "R9 bit0 fixed");
    chk(irq_lvl, 6, "R9 unmasked");
    wr(5'h01, 8'h00); wr(5'h09, 8'h00); wr(5'h0C, 8'h00);
    req_i[1] = 0; req_i[9] = 0; req_i[12] = 0;
  endtask

  task automatic t_hole;
    wr(5'h11, 8'h40);
    req_i[11] = 1;
    wr(5'h0B, 8'h16);
    rd(5'h0B, 8'h00, "R10 hole reads zero");
    chk(irq_lvl, 0, "R10 hole no irq");
    ack(3'd6, 0, 8'h00, "R10 no hole vector");
    req_i[11] = 0;
  endtask

  initial begin
    repeat (2) @(negedge clk);
    t_reset;
    rst_n = 1;
    @(negedge clk);
    t_fields;
    t_edge;
    t_level;
    t_master;
    t_disable;
    t_prio;
    t_mask;
    t_hole;
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule